// File: doc/BRIEF.md
# E1 Timeslot 16 Signaling Inserter

This block builds the timeslot 16 byte of an E1 transmit frame when channel-associated signaling is in use. A control byte stream arrives from the backplane, one byte per backplane timeslot. Each byte holds the four signaling bits (A, B, C, D) of one voice channel in its low nibble. The block keeps the latest nibble of each of the 30 voice channels. Once per frame it emits the byte that goes into timeslot 16. Across a 16-frame signaling multiframe, frame 0 carries the alignment byte and frames 1 to 15 each carry two channels' nibbles.

The backplane runs either at 2.048 Mbit/s with one framer or at 8.192 Mbit/s with four framers interleaved byte by byte. In the fast mode the block accepts only the bytes that belong to its own framer number. Captured nibbles pass through a second register bank that loads at the multiframe boundary, so every multiframe transmits one consistent snapshot. A frame tick advances an internal frame counter, and a sync pulse forces that counter to frame 0.

Top module: `cas_ts16_inserter`

## Requirements
- R1: Each cycle with `frame_tick` high and `mf_sync` low advances `mf_frame` by one, wrapping from 15 to 0. `mf_frame`, `ts16_byte` and `ts16_ins` change only on a cycle after a tick, and each updates one clock after the tick.
- R2: A tick with `mf_sync` high sets `mf_frame` to 0, whatever its previous value.
- R3: On entry to frame 0 in signaling mode, `ts16_byte` becomes `{4'b0000, spare_bits}`, with bits 7..4 zero.
- R4: On entry to frame k (1..15) in signaling mode, `ts16_byte[7:4]` is the stored nibble of channel k and `ts16_byte[3:0]` is that of channel k+15. Signal A is the most significant bit of each nibble.
- R5: At 2.048 Mbit/s (`bus_mode`=0), control slot t in 1..15 updates channel t and slot t in 17..31 updates channel t-1. The nibble is `ctl_data[3:0]`, with A in bit 3. `ctl_data[7:4]` is ignored.
- R6: Control slots 0 and 16 write nothing. At 2.048 Mbit/s, slot indices 32 and above write nothing.
- R7: At 8.192 Mbit/s (`bus_mode`=1), slot index s maps to timeslot t = s/4 and framer n = s mod 4. The byte is captured only when n equals `framer_sel`, and then as in R5.
- R8: A nibble written during a multiframe is transmitted only from the next entry to frame 0 onward.
- R9: A write to a channel whose bit in `chan_en` is low (bit c for channel c+1) leaves that channel's stored nibble unchanged.
- R10: A tick with `ccs_mode` high gives `ts16_byte`=8'hFF and `ts16_ins`=0. A tick with `ccs_mode` low gives `ts16_ins`=1.
- R11: Reset gives `ts16_byte`=8'hFF, `ts16_ins`=0 and `mf_frame`=15. Every channel's nibble starts at the idle value 4'b1101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per E1 frame |
| mf_sync | input | 1 | With `frame_tick`, forces frame 0 |
| ccs_mode | input | 1 | 1 selects common-channel mode and disables insertion |
| bus_mode | input | 1 | 0 selects 2.048 Mbit/s, 1 selects 8.192 Mbit/s |
| framer_sel | input | FR_W | Framer number in fast mode |
| chan_en | input | 30 | Per-channel capture enable |
| spare_bits | input | 4 | Low nibble of the alignment byte |
| ctl_valid | input | 1 | Control byte present |
| ctl_slot | input | FR_W+5 | Backplane slot index of the control byte |
| ctl_data | input | 8 | Control byte |
| ts16_byte | output | 8 | Timeslot 16 byte for the current frame |
| ts16_ins | output | 1 | Byte is signaling to be inserted |
| mf_frame | output | 4 | Current frame number in the multiframe |

## Verification
The assertions check the frame sequencing on every cycle: advancing, wrapping, forcing to 0, and holding between ticks. They also check the alignment byte on entry to frame 0, the forced idle output in common-channel mode and the reset values. The rest can only be shown by the bench's scenarios, because it depends on stored contents: the slot-to-channel mapping in both bus modes, the filtering by framer, the rejection of slots 0 and 16, the per-channel enable, and the one-multiframe delay of the double buffer.

// File: rtl/cas_pkg.sv
`timescale 1ns/1ps
package cas_pkg;
  localparam int NUM_CH  = 30;          // voice channels
  localparam int HALF_CH = NUM_CH / 2;  // channels per nibble half
  localparam int TS_W    = 5;           // E1 timeslot index width
  localparam int IDX_W   = $clog2(NUM_CH);
  localparam int NIB_W   = 4;
  localparam int MF_LEN  = 16;
  localparam int MF_W    = $clog2(MF_LEN);
  localparam int BYTE_W  = 8;
  localparam int TS_SIG  = 16;          // timeslot carrying signaling

  typedef logic [NIB_W-1:0] abcd_t;
  typedef logic [IDX_W-1:0] ch_idx_t;
  typedef logic [MF_W-1:0]  mf_num_t;
endpackage

// File: rtl/cas_slot_decode.sv
`timescale 1ns/1ps
// Maps a backplane control slot to a channel index and registers the write.
module cas_slot_decode
  import cas_pkg::*;
#(
  parameter int FR_W   = 2,
  parameter int SLOT_W = TS_W + FR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              bus_mode,
  input  logic [FR_W-1:0]   framer_sel,
  output logic              wr_en,
  output ch_idx_t           wr_idx,
  output abcd_t             wr_nib
);
  logic [TS_W-1:0] ts;
  logic            in_range;
  logic            ts_used;
  ch_idx_t         idx_c;

  always_comb begin
    if (bus_mode) begin
      ts       = in_slot[SLOT_W-1 -: TS_W];
      in_range = (in_slot[FR_W-1:0] == framer_sel);
    end else begin
      ts       = in_slot[TS_W-1:0];
      in_range = (in_slot[SLOT_W-1:TS_W] == '0);
    end
    ts_used = (ts != '0) && (ts != TS_W'(TS_SIG));
    if (ts < TS_W'(TS_SIG)) idx_c = ch_idx_t'(ts - TS_W'(1));
    else                    idx_c = ch_idx_t'(ts - TS_W'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_nib <= '0;
    end else begin
      wr_en  <= in_valid && in_range && ts_used;
      wr_idx <= idx_c;
      wr_nib <= in_data[NIB_W-1:0];
    end
  end
endmodule

// File: rtl/cas_sig_store.sv
`timescale 1ns/1ps
// Capture bank plus transmit snapshot bank, one cell per channel.
module cas_sig_store
  import cas_pkg::*;
#(
  parameter abcd_t IDLE = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  ch_idx_t           wr_idx,
  input  abcd_t             wr_nib,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic              swap,
  input  ch_idx_t           rd_idx_a,
  input  ch_idx_t           rd_idx_b,
  output abcd_t             rd_a,
  output abcd_t             rd_b
);
  abcd_t cap_q [NUM_CH];
  abcd_t shd_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cap_q[c] <= IDLE;
        shd_q[c] <= IDLE;
      end else begin
        if (wr_en && (wr_idx == ch_idx_t'(c)) && chan_en[c])
          cap_q[c] <= wr_nib;
        if (swap)
          shd_q[c] <= cap_q[c];
      end
    end
  end

  always_comb begin
    rd_a = (int'(rd_idx_a) < NUM_CH) ? shd_q[rd_idx_a] : IDLE;
    rd_b = (int'(rd_idx_b) < NUM_CH) ? shd_q[rd_idx_b] : IDLE;
  end
endmodule

// File: rtl/cas_mf_seq.sv
`timescale 1ns/1ps
// Multiframe frame counter with sync load.
module cas_mf_seq
  import cas_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    frame_tick,
  input  logic    mf_sync,
  output mf_num_t frame_q,
  output mf_num_t next_frame,
  output logic    mf_boundary
);
  always_comb begin
    next_frame  = mf_sync ? '0 : mf_num_t'(frame_q + 1'b1);
    mf_boundary = frame_tick && (next_frame == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)             frame_q <= mf_num_t'(MF_LEN - 1);
    else if (frame_tick) frame_q <= next_frame;
  end
endmodule

// File: rtl/cas_ts16_inserter.sv
`timescale 1ns/1ps
module cas_ts16_inserter
  import cas_pkg::*;
#(
  parameter int    FR_W   = 2,
  parameter abcd_t IDLE   = 4'b1101,
  parameter int    SLOT_W = TS_W + FR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic              mf_sync,
  input  logic              ccs_mode,
  input  logic              bus_mode,
  input  logic [FR_W-1:0]   framer_sel,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NIB_W-1:0]  spare_bits,
  input  logic              ctl_valid,
  input  logic [SLOT_W-1:0] ctl_slot,
  input  logic [BYTE_W-1:0] ctl_data,
  output logic [BYTE_W-1:0] ts16_byte,
  output logic              ts16_ins,
  output logic [MF_W-1:0]   mf_frame
);
  logic    wr_en;
  ch_idx_t wr_idx;
  abcd_t   wr_nib;
  mf_num_t frame_q, next_frame;
  logic    mf_boundary;
  ch_idx_t idx_first, idx_second;
  abcd_t   nib_first, nib_second;
  logic [BYTE_W-1:0] ts16_q;
  logic    ins_q;

  cas_slot_decode #(.FR_W(FR_W), .SLOT_W(SLOT_W)) dec_i (
    .clk(clk), .rst(rst), .in_valid(ctl_valid), .in_slot(ctl_slot),
    .in_data(ctl_data), .bus_mode(bus_mode), .framer_sel(framer_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_nib(wr_nib)
  );

  cas_mf_seq seq_i (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .mf_sync(mf_sync),
    .frame_q(frame_q), .next_frame(next_frame), .mf_boundary(mf_boundary)
  );

  // frame k reads channel k (index k-1) and channel k+15 (index k+14)
  always_comb begin
    idx_first  = ch_idx_t'(next_frame) - ch_idx_t'(1);
    idx_second = ch_idx_t'(next_frame) + ch_idx_t'(HALF_CH - 1);
  end

  cas_sig_store #(.IDLE(IDLE)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_nib(wr_nib),
    .chan_en(chan_en), .swap(mf_boundary),
    .rd_idx_a(idx_first), .rd_idx_b(idx_second),
    .rd_a(nib_first), .rd_b(nib_second)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts16_q <= '1;
      ins_q  <= 1'b0;
    end else if (frame_tick) begin
      if (ccs_mode) begin
        ts16_q <= '1;
        ins_q  <= 1'b0;
      end else if (next_frame == '0) begin
        ts16_q <= {{NIB_W{1'b0}}, spare_bits};
        ins_q  <= 1'b1;
      end else begin
        ts16_q <= {nib_first, nib_second};
        ins_q  <= 1'b1;
      end
    end
  end

  assign ts16_byte = ts16_q;
  assign ts16_ins  = ins_q;
  assign mf_frame  = frame_q;
endmodule

// File: rtl/cas_ts16_inserter_chk.sv
`timescale 1ns/1ps
module cas_ts16_inserter_chk
  import cas_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              frame_tick,
  input logic              mf_sync,
  input logic              ccs_mode,
  input logic [NIB_W-1:0]  spare_bits,
  input logic [BYTE_W-1:0] ts16_byte,
  input logic              ts16_ins,
  input logic [MF_W-1:0]   mf_frame
);
  a_r1_frame_advance: assert property (@(posedge clk) disable iff (rst)
    frame_tick && !mf_sync |=> mf_frame == $past(mf_frame) + 4'd1);

  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(mf_frame) && $stable(ts16_byte) && $stable(ts16_ins));

  a_r2_sync_to_zero: assert property (@(posedge clk) disable iff (rst)
    frame_tick && mf_sync |=> mf_frame == 4'd0);

  a_r3_align_byte: assert property (@(posedge clk) disable iff (rst)
    frame_tick && !ccs_mode && (mf_sync || mf_frame == 4'd15)
    |=> ts16_byte == {4'b0000, $past(spare_bits)} && ts16_ins);

  a_r10_ccs_idle: assert property (@(posedge clk) disable iff (rst)
    frame_tick && ccs_mode |=> ts16_byte == 8'hFF && !ts16_ins);

  a_r10_cas_insert: assert property (@(posedge clk) disable iff (rst)
    frame_tick && !ccs_mode |=> ts16_ins);

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> ts16_byte == 8'hFF && !ts16_ins && mf_frame == 4'd15);
endmodule

bind cas_ts16_inserter cas_ts16_inserter_chk chk_i (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .mf_sync(mf_sync),
  .ccs_mode(ccs_mode), .spare_bits(spare_bits), .ts16_byte(ts16_byte),
  .ts16_ins(ts16_ins), .mf_frame(mf_frame)
);

// File: tb/cas_ts16_inserter_tb_top.sv
`timescale 1ns/1ps
module cas_ts16_inserter_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, frame_tick, mf_sync, ccs_mode, bus_mode, ctl_valid;
  logic [1:0]  framer_sel;
  logic [29:0] chan_en;
  logic [3:0]  spare_bits;
  logic [6:0]  ctl_slot;
  logic [7:0]  ctl_data, ts16_byte;
  logic        ts16_ins;
  logic [3:0]  mf_frame;

  cas_ts16_inserter dut_i (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .mf_sync(mf_sync),
    .ccs_mode(ccs_mode), .bus_mode(bus_mode), .framer_sel(framer_sel),
    .chan_en(chan_en), .spare_bits(spare_bits), .ctl_valid(ctl_valid),
    .ctl_slot(ctl_slot), .ctl_data(ctl_data), .ts16_byte(ts16_byte),
    .ts16_ins(ts16_ins), .mf_frame(mf_frame)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] m_cap [30];
  logic [3:0] m_shd [30];
  int fc;

  // {bus_mode, framer_sel[1:0], slot[6:0], data[7:0], expected channel[4:0]} (0 = ignored)
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 7'd1,   8'hA5, 5'd1},   // R5 upper nibble ignored
    {1'b0, 2'd0, 7'd15,  8'h3C, 5'd15},  // R5
    {1'b0, 2'd0, 7'd17,  8'hF2, 5'd16},  // R5
    {1'b0, 2'd0, 7'd31,  8'h09, 5'd30},  // R5
    {1'b0, 2'd0, 7'd0,   8'h07, 5'd0},   // R6
    {1'b0, 2'd0, 7'd16,  8'h08, 5'd0},   // R6
    {1'b0, 2'd0, 7'd40,  8'h0E, 5'd0},   // R6 out of range at 2.048
    {1'b1, 2'd2, 7'd14,  8'h66, 5'd3},   // R7 t=3 n=2
    {1'b1, 2'd2, 7'd13,  8'h01, 5'd0},   // R7 other framer
    {1'b1, 2'd2, 7'd82,  8'h4B, 5'd19},  // R7 t=20
    {1'b1, 2'd2, 7'd66,  8'h0A, 5'd0},   // R7 t=16
    {1'b1, 2'd2, 7'd126, 8'hE4, 5'd30},  // R7 t=31 overwrites
    {1'b1, 2'd2, 7'd2,   8'h03, 5'd0}    // R7 t=0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] slot, input logic [7:0] data, input int expch);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_slot = slot; ctl_data = data;
    @(negedge clk);
    ctl_valid = 1'b0;
    if (expch != 0 && chan_en[expch-1]) m_cap[expch-1] = data[3:0];
    repeat (2) @(negedge clk);
  endtask

  task automatic tick(input bit sync, input string tag);
    int nf;
    logic [7:0] eb;
    @(negedge clk);
    frame_tick = 1'b1; mf_sync = sync;
    nf = sync ? 0 : (fc + 1) % 16;
    if (nf == 0) m_shd = m_cap;
    if (ccs_mode)     eb = 8'hFF;
    else if (nf == 0) eb = {4'b0000, spare_bits};
    else              eb = {m_shd[nf-1], m_shd[nf+14]};
    @(negedge clk);
    frame_tick = 1'b0; mf_sync = 1'b0;
    fc = nf;
    chk({tag, " frame"}, 32'(mf_frame), 32'(nf));
    chk({tag, " byte"}, 32'(ts16_byte), 32'(eb));
    chk({tag, " ins"}, 32'(ts16_ins), 32'(!ccs_mode));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; frame_tick = 0; mf_sync = 0; ccs_mode = 0; bus_mode = 0;
    framer_sel = 0; chan_en = '1; spare_bits = 4'b1011; ctl_valid = 0;
    ctl_slot = 0; ctl_data = 0;
    for (int i = 0; i < 30; i++) begin m_cap[i] = 4'b1101; m_shd[i] = 4'b1101; end
    fc = 15;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset outputs
    chk("R11 byte", 32'(ts16_byte), 32'hFF);
    chk("R11 ins", 32'(ts16_ins), 0);
    chk("R11 frame", 32'(mf_frame), 15);

    // R11 idle storage, R3 alignment byte, R1 wrap
    for (int i = 0; i < 16; i++) tick(1'b0, "R1 R3 R4 R11");

    // vector table: R5 R6 R7 mapping
    for (int v = 0; v < NV; v++) begin
      bus_mode   = VEC[v][22];
      framer_sel = VEC[v][21:20];
      wr(VEC[v][19:13], VEC[v][12:5], int'(VEC[v][4:0]));
    end
    spare_bits = 4'b0110;
    for (int i = 0; i < 16; i++) tick(1'b0, "R4 R5 R6 R7 R3");

    // R8: write channel 20 in frame 3, old value still sent in frame 5
    bus_mode = 0;
    for (int i = 0; i < 4; i++) tick(1'b0, "R1 R8");
    wr(7'd21, 8'h07, 20);
    for (int i = 0; i < 18; i++) tick(1'b0, "R8");

    // R9: disabled channel 7 ignores a write
    chan_en[6] = 1'b0;
    wr(7'd7, 8'h0F, 7);
    for (int i = 0; i < 24; i++) tick(1'b0, "R9");
    chan_en[6] = 1'b1;

    // R10: common-channel mode
    ccs_mode = 1'b1;
    tick(1'b0, "R10");
    tick(1'b0, "R10");
    ccs_mode = 1'b0;
    tick(1'b0, "R10");

    // R2: sync from mid-multiframe
    tick(1'b0, "R2");
    tick(1'b1, "R2");
    for (int i = 0; i < 3; i++) tick(1'b0, "R2 R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule